// File: doc/BRIEF.md
# Program Cycle Write Qualifier

This block decides, inside a fast system clock domain, whether a write strobe on a parallel memory port may begin a program cycle. Three active-low control inputs (chip select, output enable, write enable) are first brought into the clock domain through a synchronizer. A write strobe exists only while chip select and write enable are both low. The strobe is accepted only if it lasts for a minimum number of clock samples, if output enable stays high for its whole duration, and if the supply lockout was clear throughout. An accepted strobe produces a single-cycle start pulse one clock after the strobe ends.

A separate supply guard holds the block locked while a supply-low comparator flag is asserted. Once the supply recovers, it keeps the block locked for a programmable power-up wait. The wait starts again from zero if the supply drops during it, or if a power-good event arrives. A lockout status output shows the guard's state, so the system, and a testbench, can see when programming is allowed.

Top module: `prog_write_qual`

## Requirements
- R1: After reset, `prog_start` is 0 and `locked` is 1.
- R2: While the synchronized `supply_low` is 1, `locked` is 1 and no `prog_start` pulse is issued.
- R3: After `supply_low` goes to 0 and stays there, `locked` stays 1 for at least `PWR_DLY_CYC` clock cycles and falls to 0 within `PWR_DLY_CYC` + `SYNC_STAGES` + 2 cycles.
- R4: If `supply_low` returns to 1 during the power-up wait, the full wait of R3 starts again from when it next returns to 0.
- R5: A one-cycle `power_good` pulse while the supply is not low sets `locked` to 1 on the next clock and starts a full power-up wait of `PWR_DLY_CYC` cycles.
- R6: A write strobe (`cs_n` = 0 and `we_n` = 0) held for at least `FILT_CYC` clock cycles, with `oe_n` = 1 throughout and the block unlocked, produces exactly one `prog_start` pulse after the strobe ends.
- R7: A write strobe shorter than `FILT_CYC` cycles produces no `prog_start` pulse.
- R8: If `oe_n` is 0 in any cycle of a write strobe, that strobe produces no `prog_start` pulse.
- R9: Write enable low while chip select is high, or chip select low while write enable is high, is not a strobe and produces no pulse, whatever its length.
- R10: A strobe during any part of which `locked` was 1 produces no pulse, even if the lockout clears before the strobe ends.
- R11: `prog_start` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| supply_low | input | 1 | Supply-below-threshold comparator flag, asynchronous |
| power_good | input | 1 | One-cycle power-good event, synchronous to clk |
| prog_start | output | 1 | One-cycle program-start pulse |
| locked | output | 1 | 1 while programming is locked out by supply guard |

## Verification
The bench aims at strobes exactly one cycle shorter than the filter count and exactly at it. A filter off by one would fire on the short strobe or swallow the minimum one. It spoils strobes with a single cycle of output enable low, and with chip select or write enable alone. It also holds a strobe across the end of a power-up wait, which a design that checks the lockout only when the strobe ends would wrongly accept. It bounces the supply flag during the wait and sends a power-good event after unlock. A timer that resumes rather than restarts would unlock early there, and one that ignores the event would never relock.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

   typedef enum logic [1:0] {
      PW_LOW   = 2'd0,
      PW_WAIT  = 2'd1,
      PW_READY = 2'd2
   } pw_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/pwq_sync.sv
module pwq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      if (STAGES > 4) $error("pwq_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pwq_strobe_filter.sv
module pwq_strobe_filter #(
   parameter int unsigned FILT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic we_n_s,
   input  logic oe_n_s,
   input  logic lock,
   output logic start
);

   localparam int unsigned WCW = pwq_pkg::cnt_width(FILT_CYC);
   localparam logic [WCW-1:0] WMAX = WCW'(FILT_CYC);

   initial begin
      if (FILT_CYC < 1) $error("pwq_strobe_filter: FILT_CYC must be at least 1");
   end

   logic           str_act;
   logic           str_q;
   logic           spoil;
   logic [WCW-1:0] wcnt;
   logic           str_end;

   assign str_act = ~cs_n_s & ~we_n_s;
   assign str_end = str_q & ~str_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         str_q <= 1'b0;
         wcnt  <= '0;
         spoil <= 1'b0;
         start <= 1'b0;
      end else begin
         str_q <= str_act;
         if (!str_act) begin
            wcnt  <= '0;
            spoil <= 1'b0;
         end else begin
            if (wcnt != WMAX) wcnt <= wcnt + 1'b1;
            if (!oe_n_s || lock) spoil <= 1'b1;
         end
         start <= str_end & (wcnt == WMAX) & ~spoil & ~lock;
      end
   end

   // R11: a start pulse lasts one cycle
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   // R6: a pulse follows a strobe that was active and then ended
   a_r6_after_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (!$past(str_act) && $past(str_q)));

   // R7: width counter saturates at the filter count
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= WMAX);

   // R8: output enable low inside a strobe leaves it spoiled until it ends
   a_r8_oe_spoils: assert property (@(posedge clk) disable iff (!rst_n)
      (str_act && !oe_n_s) |=> (spoil || !str_act));

endmodule

// File: rtl/pwq_power_timer.sv
module pwq_power_timer
   import pwq_pkg::*;
#(
   parameter int unsigned PWR_DLY_CYC = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_low_s,
   input  logic pg_evt,
   output logic lock
);

   localparam int unsigned DCW  = cnt_width(PWR_DLY_CYC - 1);
   localparam logic [DCW-1:0] LAST = DCW'(PWR_DLY_CYC - 1);

   initial begin
      if (PWR_DLY_CYC < 2) $error("pwq_power_timer: PWR_DLY_CYC must be at least 2");
   end

   pw_state_t      state, state_nx;
   logic [DCW-1:0] cnt, cnt_nx;

   always_comb begin
      state_nx = state;
      cnt_nx   = cnt;
      if (sup_low_s) begin
         state_nx = PW_LOW;
         cnt_nx   = '0;
      end else if (pg_evt) begin
         state_nx = PW_WAIT;
         cnt_nx   = '0;
      end else begin
         unique case (state)
            PW_LOW: begin
               state_nx = PW_WAIT;
               cnt_nx   = '0;
            end
            PW_WAIT: begin
               if (cnt == LAST) state_nx = PW_READY;
               else             cnt_nx   = cnt + 1'b1;
            end
            PW_READY: ;
            default: begin
               state_nx = PW_LOW;
               cnt_nx   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PW_LOW;
         cnt   <= '0;
      end else begin
         state <= state_nx;
         cnt   <= cnt_nx;
      end
   end

   assign lock = (state != PW_READY);

   // R2: a low supply always forces the locked state
   a_r2_low_locks: assert property (@(posedge clk) disable iff (!rst_n)
      sup_low_s |=> (state == PW_LOW));

   // R3: unlock only after the wait counter has run to its end
   a_r3_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PW_READY && $past(state) != PW_READY) |-> ($past(cnt) == LAST));

   // R3: counter never passes its last value
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R4: from the low state the wait begins from zero
   a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PW_WAIT && $past(state) == PW_LOW) |-> (cnt == '0));

endmodule

// File: rtl/prog_write_qual.sv
module prog_write_qual #(
   parameter int unsigned FILT_CYC    = 4,
   parameter int unsigned PWR_DLY_CYC = 2500000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic supply_low,
   input  logic power_good,
   output logic prog_start,
   output logic locked
);

   logic [3:0] raw, syn;
   logic       lock_i;

   assign raw = {supply_low, oe_n, we_n, cs_n};

   pwq_sync #(
      .STAGES (SYNC_STAGES),
      .W      (4),
      .RST_VAL(4'b1111)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (syn)
   );

   pwq_power_timer #(
      .PWR_DLY_CYC(PWR_DLY_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sup_low_s(syn[3]),
      .pg_evt   (power_good),
      .lock     (lock_i)
   );

   pwq_strobe_filter #(
      .FILT_CYC(FILT_CYC)
   ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n_s(syn[0]),
      .we_n_s(syn[1]),
      .oe_n_s(syn[2]),
      .lock  (lock_i),
      .start (prog_start)
   );

   assign locked = lock_i;

   // R10: a start is only issued when the guard was clear one cycle earlier
   a_r10_no_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !$past(locked));

   // R5: a power-good event with good supply relocks on the next clock
   a_r5_pg_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      (power_good && !syn[3]) |=> locked);

   // R9: a start needs both strobe inputs to have been low
   a_r9_both_low: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> ($past(syn[0], 2) == 1'b0 && $past(syn[1], 2) == 1'b0));

endmodule

// File: tb/prog_write_qual_test.sv
`timescale 1ns/1ps
module prog_write_qual_test;

   localparam int FILT = 4;
   localparam int DLY  = 50;
   localparam int SYN  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic supply_low = 1'b1, power_good = 1'b0;
   logic prog_start, locked;

   int n_chk = 0;
   int n_bad = 0;
   int pulses = 0;
   int dbl = 0;
   logic last_ps = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   prog_write_qual #(
      .FILT_CYC(FILT), .PWR_DLY_CYC(DLY), .SYNC_STAGES(SYN)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .supply_low(supply_low), .power_good(power_good),
      .prog_start(prog_start), .locked(locked)
   );

   always @(negedge clk) begin
      if (prog_start) pulses++;
      if (prog_start && last_ps) dbl++;
      last_ps = prog_start;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // mode 0: both low, 1: we only, 2: cs only
   function automatic int exp_pulses(input int len, input int mode,
                                     input bit spoil_oe, input bit lck);
      if (mode != 0 || spoil_oe || lck) return 0;
      return (len >= FILT) ? 1 : 0;
   endfunction

   task automatic strobe(input int len, input int mode, input int oe_at);
      @(negedge clk);
      if (mode != 2) we_n = 1'b0;
      if (mode != 1) cs_n = 1'b0;
      for (int i = 0; i < len; i++) begin
         oe_n = (i == oe_at) ? 1'b0 : 1'b1;
         @(negedge clk);
      end
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (SYN + 4) @(negedge clk);
   endtask

   task automatic run_strobe(input string tag, input int len, input int mode,
                             input int oe_at);
      int p0;
      p0 = pulses;
      strobe(len, mode, oe_at);
      check(tag, pulses - p0, exp_pulses(len, mode, (oe_at >= 0 && oe_at < len), 1'b0));
   endtask

   task automatic supply_up_check(input string tag);
      supply_low = 1'b0;
      repeat (DLY + 1) @(negedge clk);
      check({tag, " still locked"}, int'(locked), 1);
      repeat (3) @(negedge clk);
      check({tag, " unlocked"}, int'(locked), 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 prog_start", int'(prog_start), 0);
      check("R1 locked", int'(locked), 1);
      rst_n = 1'b1;

      // R2: strobe while supply low
      repeat (5) @(negedge clk);
      check("R2 locked low supply", int'(locked), 1);
      begin
         int p0;
         p0 = pulses;
         strobe(FILT + 3, 0, -1);
         check("R2 no start low supply", pulses - p0, 0);
      end

      // R4: bounce during wait, then R3 full wait
      supply_low = 1'b0;
      repeat (30) @(negedge clk);
      supply_low = 1'b1;
      repeat (4) @(negedge clk);
      check("R4 relocked after bounce", int'(locked), 1);
      supply_up_check("R4 R3 wait after bounce");

      // R6, R7, R8, R9 directed corner cases
      run_strobe("R7 len FILT-1", FILT - 1, 0, -1);
      run_strobe("R6 len FILT", FILT, 0, -1);
      run_strobe("R6 long", FILT + 9, 0, -1);
      run_strobe("R8 oe low first", FILT + 2, 0, 0);
      run_strobe("R8 oe low last", FILT + 2, 0, FILT + 1);
      run_strobe("R9 we only", FILT + 5, 1, -1);
      run_strobe("R9 cs only", FILT + 5, 2, -1);
      run_strobe("R7 len 1", 1, 0, -1);

      // R5: power-good relocks and restarts wait
      @(negedge clk);
      power_good = 1'b1;
      @(negedge clk);
      power_good = 1'b0;
      check("R5 relock", int'(locked), 1);
      repeat (DLY - 2) @(negedge clk);
      check("R5 wait held", int'(locked), 1);
      repeat (4) @(negedge clk);
      check("R5 unlocked", int'(locked), 0);

      // R10: strobe spans end of wait
      @(negedge clk);
      power_good = 1'b1;
      @(negedge clk);
      power_good = 1'b0;
      begin
         int p0;
         p0 = pulses;
         strobe(DLY + 10, 0, -1);
         check("R10 unlocked", int'(locked), 0);
         check("R10 no start across lockout", pulses - p0, 0);
      end

      // random mix, R6 R7 R8 R9
      for (int k = 0; k < 60; k++) begin
         int len, mode, oe_at;
         len  = 1 + int'($urandom_range(0, 8));
         mode = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 2)) : 0;
         oe_at = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, len - 1)) : -1;
         run_strobe("R6 R7 R8 R9 random", len, mode, oe_at);
      end

      // R2 late: supply drop relocks
      supply_low = 1'b1;
      repeat (SYN + 2) @(negedge clk);
      check("R2 relock on drop", int'(locked), 1);

      check("R11 no double pulse", dbl, 0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule